// File: doc/BRIEF.md
# Banked Window Address Mapper

This block sits between a CPU port and video memory. The CPU side sees a 128 KB legacy video window. The mapper turns one CPU byte access inside that window into the video-memory byte cycles needed for extended packed-pixel modes. It picks a bank offset register and scales it by the selected bank granularity. It then takes one of two paths:

- **Linear:** with chain-4 on, it makes a single byte access.
- **Replicated planar:** with chain-4 off, it makes 4 or 8 plane accesses under a plane mask. Writes copy the CPU byte into every enabled plane. Reads OR together the bytes of the enabled planes.

The accesses that the mapper does not handle are sent to a separate legacy path through a bypass strobe. These are accesses while the extensions are locked, offsets at or above 64 KB, and accesses while the display is in text mode or screen-off. The legacy latch and logic-operation datapath sits on that legacy path and is not part of this block.

**Request handshake.** A requester raises `cpu_req` with the access fields and holds them until `cpu_ready` pulses. The request is sampled only when the sequencer is idle.

**Sequencer states.**

| State | What happens |
|---|---|
| `ST_IDLE` | Waits for a request and latches the decoded access. |
| `ST_PASS` | One cycle that raises the bypass strobe and ready together. |
| `ST_PLANE` | Steps a plane counter and issues one video-memory cycle per enabled plane, or one cycle in linear mode. |
| `ST_FLUSH` | Waits one cycle so the last read byte returns. |
| `ST_DONE` | Presents ready and the gathered read data. |

**Transitions.**

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_PASS` | Request that must be bypassed |
| `ST_IDLE` | `ST_PLANE` | Request that the mapper handles |
| `ST_PLANE` | `ST_PLANE` | More planes remain |
| `ST_PLANE` | `ST_FLUSH` | Last plane step done |
| `ST_FLUSH` | `ST_DONE` | Always, after one cycle |
| `ST_PASS` | `ST_IDLE` | Always, after one cycle |
| `ST_DONE` | `ST_IDLE` | Always, after one cycle |

Top module: `aperture_mapper`

## Requirements
- R1: An access is bypassed when any of these holds: `ext_lock` is high, offset bit 16 is set, `text_mode` is high, or `screen_off` is high. A bypassed access asserts `byp_fwd` and `cpu_ready` in the same single cycle, one clock after the request is sampled. It makes no video-memory cycle and returns `cpu_rdata` = 0x00.
- R2: With `ext_dual` high, offsets 0x0000–0x7FFF use `bank0`. Offsets 0x8000–0xFFFF use `bank1` with 0x8000 removed. The window offset keeps 15 bits.
- R3: With `ext_dual` low, `bank0` is always used and the window offset keeps all 16 bits.
- R4: The bank base is the bank value times 0x1000. When `ext_gran16` is high it is the bank value times 0x4000 instead. With chain-4 off, the base is also shifted left by 2.
- R5: With `chain4` high, exactly one byte cycle is made, at (window offset + base) modulo 2^VRAM_AW.
- R6: With `chain4` low in 4-plane mode, plane i (0–3) is accessed at offset×4 + i + base. This happens only when plane-mask bit i is 1, and mask bits 7:4 are ignored.
- R7: Eight planes are used, at offset×8 + i + base, when the effective write mode is 4 or 5, or when it is 1 and `ext_wm3` is high.
- R8: The effective write mode is all three bits of `wmode` only when `ext_wm3` is high. Otherwise it is `wmode[1:0]`, so `wmode` = 5 with `ext_wm3` low acts as mode 1 in 4-plane mode.
- R9: A planar read returns the OR of the bytes of the enabled planes. A read with no enabled plane makes no video-memory cycle and returns 0x00.
- R10: `cpu_ready` is a single-cycle pulse with valid `cpu_rdata`. For a mapped access it comes N+2 clocks after the request is sampled, where N is 1 in linear mode and 4 or 8 in planar mode. It is never high while a video-memory cycle is in progress.
- R11: After reset, `cpu_ready`, `byp_fwd` and `vram_en` are low.
- R12: Video-memory reads return `vram_rdata` one clock after the cycle is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_off | input | OFF_W (17) | Byte offset inside the 128 KB window |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid with ready |
| cpu_ready | output | 1 | Access-complete pulse |
| byp_fwd | output | 1 | Access belongs to the legacy path |
| ext_lock | input | 1 | Extension registers locked |
| text_mode | input | 1 | Display is in text mode |
| screen_off | input | 1 | Display is blanked |
| ext_dual | input | 1 | Two-bank window split enable |
| ext_wm3 | input | 1 | Three-bit write mode enable |
| ext_gran16 | input | 1 | 16 KB bank granularity |
| chain4 | input | 1 | Linear (chain-4) addressing |
| wmode | input | 3 | Write mode field |
| plane_mask | input | 8 | Plane enable mask |
| bank0 | input | BANK_W (8) | Bank offset register 0 |
| bank1 | input | BANK_W (8) | Bank offset register 1 |
| vram_en | output | 1 | Video-memory cycle strobe |
| vram_we | output | 1 | Video-memory write |
| vram_addr | output | VRAM_AW (20) | Video-memory byte address |
| vram_wdata | output | 8 | Video-memory write byte |
| vram_rdata | input | 8 | Video-memory read byte (1-cycle latency) |

## Verification
The linear path is tried three ways:

- with one bank and a full 16-bit offset;
- with the two-bank split on either side of 0x8000, which shows whether the right bank is picked and 0x8000 removed;
- with 16 KB granularity, which separates the two base scalings.

Planar accesses use sparse masks with distinct bytes per plane. These show the address-lane order, that masked planes are skipped, and that a read ORs its planes and does not return only the last plane read. Write-mode values 1 and 5, with `ext_wm3` high and low, separate the 4-plane and 8-plane strides. The four bypass causes are each tried alone, and the cycle count to ready is checked in every mode.

// File: rtl/amap_pkg.sv
package amap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_PLANE,
        ST_FLUSH,
        ST_DONE
    } amap_state_e;

    localparam int GRAN_SH_SMALL = 12;  // 4 KB
    localparam int GRAN_SH_LARGE = 14;  // 16 KB
    localparam int PLANAR_SH     = 2;   // base scaling when chain-4 is off

    // Effective write mode: upper bit only honoured when 3-bit mode enabled
    function automatic logic [2:0] eff_wmode(input logic wm3, input logic [2:0] wm);
        return wm3 ? wm : {1'b0, wm[1:0]};
    endfunction

endpackage

// File: rtl/amap_decode.sv
module amap_decode
    import amap_pkg::*;
#(
    parameter int OFF_W   = 17,
    parameter int BANK_W  = 8,
    parameter int VRAM_AW = 20
) (
    input  logic [OFF_W-1:0]   cpu_off,
    input  logic               ext_lock,
    input  logic               text_mode,
    input  logic               screen_off,
    input  logic               ext_dual,
    input  logic               ext_wm3,
    input  logic               ext_gran16,
    input  logic               chain4,
    input  logic [2:0]         wmode,
    input  logic [BANK_W-1:0]  bank0,
    input  logic [BANK_W-1:0]  bank1,
    output logic               bypass,
    output logic [OFF_W-2:0]   win_off,
    output logic [VRAM_AW-1:0] base_addr,
    output logic               wide8
);
    localparam int LIN_W  = OFF_W - 1;
    localparam int HALF_W = LIN_W - 1;
    localparam int SCL_W  = BANK_W + GRAN_SH_LARGE + PLANAR_SH;

    logic              hi_half;
    logic [BANK_W-1:0] bank_sel;
    logic [SCL_W-1:0]  scaled;
    logic [SCL_W-1:0]  scaled_pl;
    logic [2:0]        em;

    always_comb begin
        bypass  = ext_lock | cpu_off[OFF_W-1] | text_mode | screen_off;
        hi_half = ext_dual & cpu_off[HALF_W];
        if (ext_dual)
            win_off = {1'b0, cpu_off[HALF_W-1:0]};
        else
            win_off = cpu_off[LIN_W-1:0];
        bank_sel  = hi_half ? bank1 : bank0;
        scaled    = SCL_W'(bank_sel) << (ext_gran16 ? GRAN_SH_LARGE : GRAN_SH_SMALL);
        scaled_pl = chain4 ? scaled : (scaled << PLANAR_SH);
        base_addr = VRAM_AW'(scaled_pl);
        em        = eff_wmode(ext_wm3, wmode);
        wide8     = ~chain4 & ((em == 3'd4) | (em == 3'd5) | ((em == 3'd1) & ext_wm3));
    end

endmodule

// File: rtl/amap_seq.sv
module amap_seq
    import amap_pkg::*;
#(
    parameter int OFF_W   = 17,
    parameter int VRAM_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               we,
    input  logic               bypass,
    input  logic               chain4,
    input  logic               wide8,
    input  logic [OFF_W-2:0]   win_off,
    input  logic [VRAM_AW-1:0] base_addr,
    input  logic [7:0]         wdata,
    input  logic [7:0]         mask,
    input  logic [7:0]         vram_rdata,
    output logic               idle,
    output logic               ready,
    output logic               byp_fwd,
    output logic [7:0]         rdata,
    output logic               vram_en,
    output logic               vram_we,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [7:0]         vram_wdata
);
    localparam int    PIDX_W     = 3;
    localparam logic [PIDX_W-1:0] LAST_NARROW = 3'd3;
    localparam logic [PIDX_W-1:0] LAST_WIDE   = 3'd7;

    amap_state_e state, state_nx;

    logic               we_q, c4_q, wide_q;
    logic [OFF_W-2:0]   off_q;
    logic [VRAM_AW-1:0] base_q;
    logic [7:0]         wdata_q, mask_q, acc_q;
    logic [PIDX_W-1:0]  pidx;
    logic               rd_pend;
    logic               last_step;
    logic               plane_hit;
    logic [VRAM_AW-1:0] off_ext;

    always_comb begin
        last_step = c4_q | (pidx == (wide_q ? LAST_WIDE : LAST_NARROW));
        plane_hit = c4_q | mask_q[pidx];
        off_ext   = VRAM_AW'(off_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = bypass ? ST_PASS : ST_PLANE;
            ST_PASS:  state_nx = ST_IDLE;
            ST_PLANE: if (last_step) state_nx = ST_FLUSH;
            ST_FLUSH: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // access latch, plane counter, read gather
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            c4_q    <= 1'b0;
            wide_q  <= 1'b0;
            off_q   <= '0;
            base_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            acc_q   <= '0;
            pidx    <= '0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= vram_en & ~vram_we;
            if (rd_pend) acc_q <= acc_q | vram_rdata;
            if (state == ST_IDLE && start) begin
                we_q    <= we;
                c4_q    <= chain4;
                wide_q  <= wide8;
                off_q   <= win_off;
                base_q  <= base_addr;
                wdata_q <= wdata;
                mask_q  <= mask;
                acc_q   <= '0;
                pidx    <= '0;
            end else if (state == ST_PLANE && !last_step) begin
                pidx <= pidx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        idle       = 1'b0;
        ready      = 1'b0;
        byp_fwd    = 1'b0;
        rdata      = 8'h00;
        vram_en    = 1'b0;
        vram_we    = 1'b0;
        vram_addr  = '0;
        vram_wdata = wdata_q;
        unique case (state)
            ST_IDLE:  idle = 1'b1;
            ST_PASS: begin
                ready   = 1'b1;
                byp_fwd = 1'b1;
            end
            ST_PLANE: begin
                vram_en = plane_hit;
                vram_we = we_q;
                if (c4_q)
                    vram_addr = off_ext + base_q;
                else if (wide_q)
                    vram_addr = (off_ext << 3) + VRAM_AW'(pidx) + base_q;
                else
                    vram_addr = (off_ext << 2) + VRAM_AW'(pidx) + base_q;
            end
            ST_FLUSH: ;
            ST_DONE: begin
                ready = 1'b1;
                rdata = acc_q;
            end
            default: ;
        endcase
    end

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R10
    ready_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vram_en |-> !ready);

    // R6
    narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_en && !c4_q && !wide_q) |-> (vram_addr[1:0] == pidx[1:0]));

    // R7
    wide_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_en && !c4_q && wide_q) |-> (vram_addr[2:0] == pidx));

endmodule

// File: rtl/aperture_mapper.sv
module aperture_mapper #(
    parameter int OFF_W   = 17,
    parameter int BANK_W  = 8,
    parameter int VRAM_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic [OFF_W-1:0]   cpu_off,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_ready,
    output logic               byp_fwd,
    input  logic               ext_lock,
    input  logic               text_mode,
    input  logic               screen_off,
    input  logic               ext_dual,
    input  logic               ext_wm3,
    input  logic               ext_gran16,
    input  logic               chain4,
    input  logic [2:0]         wmode,
    input  logic [7:0]         plane_mask,
    input  logic [BANK_W-1:0]  bank0,
    input  logic [BANK_W-1:0]  bank1,
    output logic               vram_en,
    output logic               vram_we,
    output logic [VRAM_AW-1:0] vram_addr,
    output logic [7:0]         vram_wdata,
    input  logic [7:0]         vram_rdata
);
    logic               dec_bypass;
    logic [OFF_W-2:0]   dec_off;
    logic [VRAM_AW-1:0] dec_base;
    logic               dec_wide;
    logic               seq_idle;

    amap_decode #(.OFF_W(OFF_W), .BANK_W(BANK_W), .VRAM_AW(VRAM_AW)) u_dec (
        .cpu_off    (cpu_off),
        .ext_lock   (ext_lock),
        .text_mode  (text_mode),
        .screen_off (screen_off),
        .ext_dual   (ext_dual),
        .ext_wm3    (ext_wm3),
        .ext_gran16 (ext_gran16),
        .chain4     (chain4),
        .wmode      (wmode),
        .bank0      (bank0),
        .bank1      (bank1),
        .bypass     (dec_bypass),
        .win_off    (dec_off),
        .base_addr  (dec_base),
        .wide8      (dec_wide)
    );

    amap_seq #(.OFF_W(OFF_W), .VRAM_AW(VRAM_AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cpu_req),
        .we         (cpu_we),
        .bypass     (dec_bypass),
        .chain4     (chain4),
        .wide8      (dec_wide),
        .win_off    (dec_off),
        .base_addr  (dec_base),
        .wdata      (cpu_wdata),
        .mask       (plane_mask),
        .vram_rdata (vram_rdata),
        .idle       (seq_idle),
        .ready      (cpu_ready),
        .byp_fwd    (byp_fwd),
        .rdata      (cpu_rdata),
        .vram_en    (vram_en),
        .vram_we    (vram_we),
        .vram_addr  (vram_addr),
        .vram_wdata (vram_wdata)
    );

    // R1
    high_off_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && seq_idle && cpu_off[OFF_W-1]) |=> (byp_fwd && cpu_ready && !vram_en));

    // R1
    bypass_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_fwd |-> (!vram_en && cpu_rdata == 8'h00));

endmodule

// File: tb/aperture_mapper_bench.sv
module aperture_mapper_bench;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cpu_req = 0, cpu_we = 0;
    logic [16:0] cpu_off = '0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, byp_fwd;
    logic        ext_lock = 0, text_mode = 0, screen_off = 0;
    logic        ext_dual = 0, ext_wm3 = 0, ext_gran16 = 0, chain4 = 1;
    logic [2:0]  wmode = '0;
    logic [7:0]  plane_mask = 8'hFF, bank0 = '0, bank1 = '0;
    logic        vram_en, vram_we;
    logic [AW-1:0] vram_addr;
    logic [7:0]  vram_wdata, vram_rdata;

    aperture_mapper u_aperture_mapper (.*);

    // sparse video memory, 1-cycle read latency (R12)
    logic [7:0] mem [int];
    int n_wr, n_rd;
    int wr_log [16];
    bit overlap;
    always @(posedge clk) begin
        if (vram_en) begin
            if (cpu_ready) overlap <= 1'b1;
            if (vram_we) begin
                mem[int'(vram_addr)] = vram_wdata;
                if (n_wr < 16) wr_log[n_wr] = int'(vram_addr);
                n_wr++;
            end else begin
                vram_rdata <= mem.exists(int'(vram_addr)) ? mem[int'(vram_addr)] : 8'h00;
                n_rd++;
            end
        end
    end

    int checks = 0, errors = 0;
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] r_data;
    logic       r_byp;
    int         r_lat;

    task automatic access(input logic we, input logic [16:0] off, input logic [7:0] wd);
        @(negedge clk);
        n_wr = 0; n_rd = 0; overlap = 0;
        cpu_we = we; cpu_off = off; cpu_wdata = wd; cpu_req = 1'b1;
        r_lat = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #1;
            r_lat++;
            if (cpu_ready) break;
        end
        r_data = cpu_rdata;
        r_byp  = byp_fwd;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 ready", int'(cpu_ready), 0);
        chk("R11 byp", int'(byp_fwd), 0);
        chk("R11 vram_en", int'(vram_en), 0);
    endtask

    task automatic t_linear;
        chain4 = 1; ext_dual = 0; ext_gran16 = 0; bank0 = 8'd2;
        access(1, 17'h00123, 8'h5A);
        chk("R5 write count", n_wr, 1);
        chk("R5 addr", wr_log[0], 'h2123);
        chk("R10 linear latency", r_lat, 3);
        access(0, 17'h00123, 8'h00);
        chk("R5 read data", int'(r_data), 'h5A);
        chk("R5 read count", n_rd, 1);
        chk("R10 no ready during cycle", int'(overlap), 0);
        // R3 full 16-bit offset on bank0
        bank0 = 8'd0; bank1 = 8'd7;
        access(1, 17'h09000, 8'h11);
        chk("R3 addr", wr_log[0], 'h9000);
    endtask

    task automatic t_dual;
        chain4 = 1; ext_dual = 1; bank0 = 8'd1; bank1 = 8'd3;
        access(1, 17'h08010, 8'hA1);
        chk("R2 upper half addr", wr_log[0], 'h3010);
        access(1, 17'h00010, 8'hA2);
        chk("R2 lower half addr", wr_log[0], 'h1010);
        ext_dual = 0;
    endtask

    task automatic t_gran;
        chain4 = 1; ext_gran16 = 1; bank0 = 8'd2;
        access(1, 17'h00005, 8'h77);
        chk("R4 16K base", wr_log[0], 'h8005);
        ext_gran16 = 0;
        access(1, 17'h00005, 8'h78);
        chk("R4 4K base", wr_log[0], 'h2005);
    endtask

    task automatic t_planar4;
        chain4 = 0; ext_wm3 = 0; wmode = 3'd0; bank0 = 8'd1;
        plane_mask = 8'h05;
        access(1, 17'h00010, 8'h81);
        chk("R6 write count", n_wr, 2);
        chk("R6 plane0 addr", wr_log[0], 'h4040);
        chk("R6 plane2 addr", wr_log[1], 'h4042);
        chk("R10 planar latency", r_lat, 6);
        plane_mask = 8'h01; access(1, 17'h00010, 8'h03);
        plane_mask = 8'h04; access(1, 17'h00010, 8'h30);
        plane_mask = 8'h02; access(1, 17'h00010, 8'hC0);
        plane_mask = 8'h05;
        access(0, 17'h00010, 8'h00);
        chk("R9 OR read", int'(r_data), 'h33);
        chk("R9 read count", n_rd, 2);
        plane_mask = 8'h00;
        access(0, 17'h00010, 8'h00);
        chk("R9 empty mask data", int'(r_data), 0);
        chk("R9 empty mask cycles", n_rd, 0);
    endtask

    task automatic t_planar8;
        chain4 = 0; bank0 = 8'd0; plane_mask = 8'h81;
        ext_wm3 = 1; wmode = 3'd5;
        access(1, 17'h00002, 8'h44);
        chk("R7 mode5 count", n_wr, 2);
        chk("R7 plane0", wr_log[0], 'h10);
        chk("R7 plane7", wr_log[1], 'h17);
        chk("R7 wide latency", r_lat, 10);
        wmode = 3'd1;
        access(1, 17'h00002, 8'h45);
        chk("R7 mode1 wide plane7", wr_log[1], 'h17);
        ext_wm3 = 0; wmode = 3'd5;
        access(1, 17'h00002, 8'h46);
        chk("R8 narrowed count", n_wr, 1);
        chk("R8 narrowed addr", wr_log[0], 'h8);
        wmode = 3'd1;
        access(1, 17'h00002, 8'h47);
        chk("R8 mode1 no wm3 count", n_wr, 1);
    endtask

    task automatic t_bypass;
        chain4 = 1; plane_mask = 8'hFF;
        ext_lock = 1; access(1, 17'h00100, 8'h99); ext_lock = 0;
        chk("R1 lock byp", int'(r_byp), 1);
        chk("R1 lock cycles", n_wr, 0);
        chk("R1 latency", r_lat, 1);
        access(0, 17'h10000, 8'h00);
        chk("R1 high off byp", int'(r_byp), 1);
        chk("R1 high off data", int'(r_data), 0);
        chk("R1 high off cycles", n_rd, 0);
        text_mode = 1; access(1, 17'h00100, 8'h98); text_mode = 0;
        chk("R1 text byp", int'(r_byp), 1);
        chk("R1 text cycles", n_wr, 0);
        screen_off = 1; access(1, 17'h00100, 8'h97); screen_off = 0;
        chk("R1 off byp", int'(r_byp), 1);
        access(1, 17'h00100, 8'h96);
        chk("R1 mapped no byp", int'(r_byp), 0);
    endtask

    bit done = 0;
    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_dual();
        t_gran();
        t_planar4();
        t_planar8();
        t_bypass();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule